// File: doc/BRIEF.md
# Sixteen-Channel DMA Control and Status Register Bank

This block is the software-facing register file of a multi-channel DMA engine. It sits on a simple 32-bit peripheral bus with a single-cycle write strobe and combinational read data. It holds the global burst controls, the per-channel freeze and reset controls, the per-channel completion and error interrupt flags with their enables, and three per-channel descriptor registers: next command address, buffer address and semaphore. The channel engines that consume these values and raise events are outside the block.

Every register is reachable at three word addresses. The base offset writes the value directly. The offset four bytes higher ORs the written mask into the register. The offset eight bytes higher clears the bits of the mask. Software can therefore acknowledge or enable a single channel without a read-modify-write race. Completion, termination and bus-error pulses from the channel engines set sticky flags, and each channel gets its own interrupt line built from those flags.

Top module: `dmacsr_bank`

## Requirements
- R1: After reset every register reads zero, and every interrupt, burst, freeze and channel-reset output is low.
- R2: A write to a base offset replaces the stored value. A read from the base, the +0x4 alias or the +0x8 alias returns the same stored value.
- R3: A write to the +0x4 alias ORs the data into the register. A write to the +0x8 alias clears the bits set in the data. Bits outside the data mask are unchanged in both cases.
- R4: In the completion register at 0x010, a completion pulse on channel n sets bit n. Bits 16+n are the interrupt enables, so writing 0xFFFF0000 to 0x014 enables every channel.
- R5: In the error register at 0x020, a termination pulse on channel n sets bit n. A bus-error pulse on channel n sets both bit n and bit 16+n.
- R6: When an event pulse and a clear-alias write hit the same bit in the same cycle, the bit ends up set.
- R7: Interrupt output n is high when completion flag n and enable n are both set, or when error flag n is set. Enables do not mask error flags.
- R8: In the global control register at 0x000, bit 28 drives the burst enable output and bit 29 drives the eight-beat burst output. All other bits read zero.
- R9: In the channel control register at 0x030, bit n drives the freeze output of channel n. Writing 1 to bit 16+n through the base or +0x4 offset gives a one-cycle reset pulse on channel n in the cycle after the write. Clear-alias writes give no pulse, and bits 31:16 read zero.
- R10: Channel n has its next command address at 0x110+n*0x70, its buffer address at 0x130+n*0x70 and its semaphore at 0x140+n*0x70. Each has the same two aliases and drives its own output. The semaphore keeps only its low 8 bits.
- R11: Accesses to unmapped offsets, to the +0xC offset of any register, or to an address whose bits 1:0 are not zero change no register and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| evt_done_i | input | 16 | Per-channel completion pulse |
| evt_term_i | input | 16 | Per-channel termination pulse |
| evt_buserr_i | input | 16 | Per-channel bus-error pulse |
| irq_o | output | 16 | Per-channel interrupt line |
| burst_en_o | output | 1 | Burst transfers enabled |
| burst8_en_o | output | 1 | Eight-beat bursts enabled |
| chan_freeze_o | output | 16 | Per-channel freeze |
| chan_rst_o | output | 16 | Per-channel one-cycle reset pulse |
| next_cmd_o | output | 512 | Next command address, 32 bits per channel |
| buf_addr_o | output | 512 | Buffer address, 32 bits per channel |
| sema_o | output | 128 | Semaphore, 8 bits per channel |

## Verification
The assertions assume that the address, write flag and data are known and held for the whole cycle in which the select is high. They also assume that event inputs are free of unknowns, though events may arrive in any cycle, including during a write to the same register. The stimulus drives each bus access for exactly one cycle and lowers the select between accesses. It raises event pulses for one cycle, either alone or together with a clear-alias write to the same flag bits, so that the collision rule is exercised inside these assumptions.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

    localparam int HALF = 16;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } wr_op_e;

    localparam int unsigned GCTRL_OFS = 32'h000;
    localparam int unsigned CMPL_OFS  = 32'h010;
    localparam int unsigned ERR_OFS   = 32'h020;
    localparam int unsigned CCTRL_OFS = 32'h030;
    localparam int unsigned NXT_BASE  = 32'h110;
    localparam int unsigned BUF_BASE  = 32'h130;
    localparam int unsigned SEM_BASE  = 32'h140;
    localparam int unsigned CH_STRIDE = 32'h070;

    localparam int BIT_BURST  = 28;
    localparam int BIT_BURST8 = 29;

endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output wr_op_e            op,
    output logic              hit_gctrl,
    output logic              hit_cmpl,
    output logic              hit_err,
    output logic              hit_cctrl,
    output logic [NUM_CH-1:0] hit_nxt,
    output logic [NUM_CH-1:0] hit_buf,
    output logic [NUM_CH-1:0] hit_sem
);
    localparam int ROW_W = ADDR_W - 4;

    function automatic logic [ROW_W-1:0] row_of(input int unsigned a);
        return ROW_W'(a >> 4);
    endfunction

    logic [ROW_W-1:0] row;
    logic             ok;

    always_comb begin
        row       = addr[ADDR_W-1:4];
        ok        = (addr[1:0] == 2'b00) && (addr[3:2] != 2'b11);
        op        = ok ? wr_op_e'(addr[3:2]) : OP_NONE;
        hit_gctrl = ok && (row == row_of(GCTRL_OFS));
        hit_cmpl  = ok && (row == row_of(CMPL_OFS));
        hit_err   = ok && (row == row_of(ERR_OFS));
        hit_cctrl = ok && (row == row_of(CCTRL_OFS));
        for (int n = 0; n < NUM_CH; n++) begin
            hit_nxt[n] = ok && (row == row_of(NXT_BASE + n * CH_STRIDE));
            hit_buf[n] = ok && (row == row_of(BUF_BASE + n * CH_STRIDE));
            hit_sem[n] = ok && (row == row_of(SEM_BASE + n * CH_STRIDE));
        end
    end

endmodule

// File: rtl/dmacsr_alias_reg.sv
module dmacsr_alias_reg
    import dmacsr_pkg::*;
#(
    parameter int           W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  wr_op_e       op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt_set,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (op)
                OP_WRITE: st_d.val = wdata;
                OP_SET:   st_d.val = st_q.val | wdata;
                OP_CLR:   st_d.val = st_q.val & ~wdata;
                default:  st_d.val = st_q.val;
            endcase
        end
        st_d.val = st_d.val | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{val: RST};
        else        st_q <= st_d;
    end

    assign q = st_q.val;

    // R3
    set_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET) |=>
        ((st_q.val & $past(st_q.val | wdata)) == $past(st_q.val | wdata)));

    // R3
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLR && evt_set == '0) |=>
        ((st_q.val & $past(wdata)) == '0));

    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((st_q.val & $past(evt_set)) == $past(evt_set)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && evt_set == '0) |=> $stable(st_q.val));

endmodule

// File: rtl/dmacsr_irq_bank.sv
module dmacsr_irq_bank
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmpl,
    input  logic              wr_err,
    input  wr_op_e            op,
    input  logic [31:0]       wdata,
    input  logic [NUM_CH-1:0] evt_done,
    input  logic [NUM_CH-1:0] evt_term,
    input  logic [NUM_CH-1:0] evt_buserr,
    output logic [31:0]       cmpl_q,
    output logic [31:0]       err_q,
    output logic [NUM_CH-1:0] irq
);
    logic [31:0] cmpl_evt;
    logic [31:0] err_evt;

    always_comb begin
        cmpl_evt                 = '0;
        cmpl_evt[NUM_CH-1:0]     = evt_done;
        err_evt                  = '0;
        err_evt[NUM_CH-1:0]      = evt_term | evt_buserr;
        err_evt[HALF +: NUM_CH]  = evt_buserr;
    end

    dmacsr_alias_reg #(.W(32), .RST('0)) u_cmpl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_cmpl),
        .op      (op),
        .wdata   (wdata),
        .evt_set (cmpl_evt),
        .q       (cmpl_q)
    );

    dmacsr_alias_reg #(.W(32), .RST('0)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_err),
        .op      (op),
        .wdata   (wdata),
        .evt_set (err_evt),
        .q       (err_q)
    );

    always_comb begin
        irq = (cmpl_q[NUM_CH-1:0] & cmpl_q[HALF +: NUM_CH]) | err_q[NUM_CH-1:0];
    end

    // R5
    fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_term | evt_buserr) != '0) |=>
        ((irq & $past(evt_term | evt_buserr)) == $past(evt_term | evt_buserr)));

    // R4
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done != '0) |=>
        ((cmpl_q[NUM_CH-1:0] & $past(evt_done)) == $past(evt_done)));

endmodule

// File: rtl/dmacsr_bank.sv
module dmacsr_bank
    import dmacsr_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int SEMA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_CH-1:0]        evt_done_i,
    input  logic [NUM_CH-1:0]        evt_term_i,
    input  logic [NUM_CH-1:0]        evt_buserr_i,
    output logic [NUM_CH-1:0]        irq_o,
    output logic                     burst_en_o,
    output logic                     burst8_en_o,
    output logic [NUM_CH-1:0]        chan_freeze_o,
    output logic [NUM_CH-1:0]        chan_rst_o,
    output logic [NUM_CH*32-1:0]     next_cmd_o,
    output logic [NUM_CH*32-1:0]     buf_addr_o,
    output logic [NUM_CH*SEMA_W-1:0] sema_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] rst;
    } top_st_t;

    top_st_t top_d, top_q;

    wr_op_e            op;
    logic              hit_gctrl, hit_cmpl, hit_err, hit_cctrl;
    logic [NUM_CH-1:0] hit_nxt, hit_buf, hit_sem;
    logic              wr_stb;
    logic [1:0]        gctrl_q;
    logic [31:0]       cmpl_q, err_q;

    assign wr_stb = bus_sel & bus_wr;

    dmacsr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .op        (op),
        .hit_gctrl (hit_gctrl),
        .hit_cmpl  (hit_cmpl),
        .hit_err   (hit_err),
        .hit_cctrl (hit_cctrl),
        .hit_nxt   (hit_nxt),
        .hit_buf   (hit_buf),
        .hit_sem   (hit_sem)
    );

    dmacsr_alias_reg #(.W(2), .RST('0)) u_gctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb & hit_gctrl),
        .op      (op),
        .wdata   ({bus_wdata[BIT_BURST8], bus_wdata[BIT_BURST]}),
        .evt_set (2'b00),
        .q       (gctrl_q)
    );

    assign burst_en_o  = gctrl_q[0];
    assign burst8_en_o = gctrl_q[1];

    dmacsr_alias_reg #(.W(NUM_CH), .RST('0)) u_freeze (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_stb & hit_cctrl),
        .op      (op),
        .wdata   (bus_wdata[NUM_CH-1:0]),
        .evt_set ({NUM_CH{1'b0}}),
        .q       (chan_freeze_o)
    );

    dmacsr_irq_bank #(.NUM_CH(NUM_CH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmpl    (wr_stb & hit_cmpl),
        .wr_err     (wr_stb & hit_err),
        .op         (op),
        .wdata      (bus_wdata),
        .evt_done   (evt_done_i),
        .evt_term   (evt_term_i),
        .evt_buserr (evt_buserr_i),
        .cmpl_q     (cmpl_q),
        .err_q      (err_q),
        .irq        (irq_o)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        dmacsr_alias_reg #(.W(32), .RST('0)) u_nxt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_stb & hit_nxt[n]),
            .op      (op),
            .wdata   (bus_wdata),
            .evt_set (32'h0),
            .q       (next_cmd_o[n*32 +: 32])
        );
        dmacsr_alias_reg #(.W(32), .RST('0)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_stb & hit_buf[n]),
            .op      (op),
            .wdata   (bus_wdata),
            .evt_set (32'h0),
            .q       (buf_addr_o[n*32 +: 32])
        );
        dmacsr_alias_reg #(.W(SEMA_W), .RST('0)) u_sem (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_stb & hit_sem[n]),
            .op      (op),
            .wdata   (bus_wdata[SEMA_W-1:0]),
            .evt_set ({SEMA_W{1'b0}}),
            .q       (sema_o[n*SEMA_W +: SEMA_W])
        );
    end

    // Channel reset pulses: stored for one cycle only.
    always_comb begin
        top_d.rst = '0;
        if (wr_stb && hit_cctrl && (op == OP_WRITE || op == OP_SET)) begin
            top_d.rst = bus_wdata[HALF +: NUM_CH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign chan_rst_o = top_q.rst;

    // Read mux: all three aliases return the base register.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_gctrl) begin
                bus_rdata[BIT_BURST]  = gctrl_q[0];
                bus_rdata[BIT_BURST8] = gctrl_q[1];
            end
            if (hit_cmpl)  bus_rdata = bus_rdata | cmpl_q;
            if (hit_err)   bus_rdata = bus_rdata | err_q;
            if (hit_cctrl) bus_rdata[NUM_CH-1:0] = chan_freeze_o;
            for (int n = 0; n < NUM_CH; n++) begin
                if (hit_nxt[n]) bus_rdata = bus_rdata | next_cmd_o[n*32 +: 32];
                if (hit_buf[n]) bus_rdata = bus_rdata | buf_addr_o[n*32 +: 32];
                if (hit_sem[n]) bus_rdata[SEMA_W-1:0] = sema_o[n*SEMA_W +: SEMA_W];
            end
        end
    end

    // R9
    rst_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_rst_o != '0) |-> $past(bus_sel && bus_wr));

    // R9
    rst_not_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && hit_cctrl && op == OP_CLR) |=> (chan_rst_o == '0));

endmodule

// File: tb/dmacsr_bank_test.sv
module dmacsr_bank_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  evt_done = '0, evt_term = '0, evt_buserr = '0;
    logic [15:0]  irq, freeze, chrst;
    logic         burst, burst8;
    logic [511:0] nxt, bufa;
    logic [127:0] sema;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];

    always #10 clk = ~clk;

    dmacsr_bank uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_sel       (bus_sel),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .evt_done_i    (evt_done),
        .evt_term_i    (evt_term),
        .evt_buserr_i  (evt_buserr),
        .irq_o         (irq),
        .burst_en_o    (burst),
        .burst8_en_o   (burst8),
        .chan_freeze_o (freeze),
        .chan_rst_o    (chrst),
        .next_cmd_o    (nxt),
        .buf_addr_o    (bufa),
        .sema_o        (sema)
    );

    // Monitor: compares each read cycle against the oldest expected item.
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            rd_item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL monitor: read with no expected item, got %h", bus_rdata);
            end else begin
                it = exp_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s: read %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(posedge clk); #1;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] dn, input logic [15:0] tm, input logic [15:0] be);
        @(posedge clk); #1;
        evt_done = dn; evt_term = tm; evt_buserr = be;
        @(posedge clk); #1;
        evt_done = '0; evt_term = '0; evt_buserr = '0;
    endtask

    task automatic pulse_with_write(input logic [11:0] a, input logic [31:0] d,
                                    input logic [15:0] dn, input logic [15:0] be);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        evt_done = dn; evt_buserr = be;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        evt_done = '0; evt_buserr = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, act, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq", {16'h0, irq}, 32'h0);
        chk("R1 burst", {30'h0, burst8, burst}, 32'h0);
        chk("R1 freeze/rst", {freeze, chrst}, 32'h0);
        bus_read(12'h000, 32'h0, "R1 gctrl");
        bus_read(12'h010, 32'h0, "R1 cmpl");
        bus_read(12'h020, 32'h0, "R1 err");
        bus_read(12'h110, 32'h0, "R1 nxt0");

        // R8 global burst bits
        bus_write(12'h000, 32'h3000_0000);
        @(negedge clk);
        chk("R8 burst outputs", {30'h0, burst8, burst}, 32'h3);
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_read(12'h000, 32'h3000_0000, "R8 other bits zero");
        // R3 clear alias / R2 alias read
        bus_write(12'h008, 32'h2000_0000);
        @(negedge clk);
        chk("R3 burst8 cleared", {30'h0, burst8, burst}, 32'h1);
        bus_read(12'h004, 32'h1000_0000, "R2 set alias reads base");
        bus_read(12'h008, 32'h1000_0000, "R2 clear alias reads base");

        // R4 completion flags and enables
        bus_write(12'h014, 32'hFFFF_0000);
        bus_read(12'h010, 32'hFFFF_0000, "R4 enables");
        pulse(16'h0408, 16'h0, 16'h0);
        bus_read(12'h010, 32'hFFFF_0408, "R4 completion flags");
        @(negedge clk);
        chk("R7 irq from completion", {16'h0, irq}, 32'h0408);
        bus_write(12'h018, 32'h0000_0008);
        bus_read(12'h010, 32'hFFFF_0400, "R3 clear flag");
        bus_write(12'h018, 32'h0400_0000);
        @(negedge clk);
        chk("R7 disabled completion masked", {16'h0, irq}, 32'h0);

        // R5 error flags
        pulse(16'h0, 16'h0020, 16'h0);
        bus_read(12'h020, 32'h0000_0020, "R5 termination");
        pulse(16'h0, 16'h0, 16'h0080);
        bus_read(12'h020, 32'h0080_00A0, "R5 bus error");
        @(negedge clk);
        chk("R7 errors unmasked", {16'h0, irq}, 32'h00A0);
        bus_write(12'h028, 32'hFFFF_FFFF);
        bus_read(12'h020, 32'h0, "R3 clear all errors");

        // R6 event beats clear in the same cycle
        pulse_with_write(12'h028, 32'h0004_0004, 16'h0, 16'h0004);
        bus_read(12'h020, 32'h0004_0004, "R6 error event wins");
        pulse_with_write(12'h018, 32'h0000_0002, 16'h0002, 16'h0);
        bus_read(12'h010, 32'hFBFF_0402, "R6 completion event wins");
        @(negedge clk);
        chk("R7 mixed irq", {16'h0, irq}, 32'h0006);

        // R9 channel control
        bus_write(12'h034, 32'h0009_0005);
        @(negedge clk);
        chk("R9 reset pulse", {16'h0, chrst}, 32'h0009);
        chk("R9 freeze", {16'h0, freeze}, 32'h0005);
        @(negedge clk);
        chk("R9 pulse one cycle", {16'h0, chrst}, 32'h0);
        bus_read(12'h030, 32'h0000_0005, "R9 readback");
        bus_write(12'h038, 32'h0002_0001);
        @(negedge clk);
        chk("R9 clear alias no pulse", {16'h0, chrst}, 32'h0);
        chk("R9 resume", {16'h0, freeze}, 32'h0004);

        // R10 per-channel registers
        bus_write(12'h110, 32'h1234_5678);
        bus_write(12'h7C0, 32'hCAFE_0000);
        bus_write(12'h450, 32'h0000_0002);
        bus_write(12'h454, 32'h0000_0001);
        @(negedge clk);
        chk("R10 nxt0 out", nxt[31:0], 32'h1234_5678);
        chk("R10 buf15 out", bufa[15*32 +: 32], 32'hCAFE_0000);
        chk("R10 sema7 out", {24'h0, sema[7*8 +: 8]}, 32'h3);
        bus_read(12'h458, 32'h0000_0003, "R10 sema7 read");
        bus_read(12'h180, 32'h0, "R10 nxt1 untouched");
        bus_write(12'h450, 32'h0000_01FF);
        bus_read(12'h450, 32'h0000_00FF, "R10 sema width");

        // R11 ignored accesses
        bus_write(12'h00C, 32'hFFFF_FFFF);
        bus_read(12'h000, 32'h1000_0000, "R11 +C offset ignored");
        bus_read(12'h00C, 32'h0, "R11 +C reads zero");
        bus_write(12'h120, 32'hFFFF_FFFF);
        bus_read(12'h120, 32'h0, "R11 unmapped");
        bus_write(12'h112, 32'hFFFF_FFFF);
        bus_read(12'h110, 32'h1234_5678, "R11 unaligned ignored");
        bus_read(12'h014, 32'hFBFF_0402, "R2 completion alias read");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL monitor: %0d reads not observed, expected 0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule